// File: doc/BRIEF.md
# Multi-port GPIO controller with edge interrupts

A memory-mapped general-purpose I/O peripheral made of a configurable number of 8-pin ports. Each port owns a register block that repeats at a fixed stride of 0x30 bytes and has its own interrupt line. A single global control register at address 0x00 holds a clock-request enable, a stored sync-select bit, and read-only fields that report the port count and a version number.

Each pin has a two-flop synchronizer on its pad input, an output data bit, a 2-bit drive mode and a pull-up disable bit. Each pin also has a single-edge interrupt detector whose polarity is chosen per pin. It sets a sticky event bit, which software clears by writing ones. An enable bit gates the event onto the port's interrupt line. A force bit injects events for test. The block drives only digital pad controls: an output enable, an output value and a pull-up enable for each pin.

Access is through a simple register bus. A write takes effect at the clock edge on which `bus_wr` is high. Reads are combinational from `bus_addr`.

Top module: `pinbank_ctrl`

## Requirements
- R1: After reset, every writable register reads 0, every pad output enable is 0, every pull-up enable is 1 and every interrupt line is 0. The control register reads the port count in bits 15:9 and the version number in bits 8:2.
- R2: Port p registers sit at p*0x30 plus an offset: 0x04 synchronized input (read-only, writes ignored), 0x08 output data, 0x0C drive mode (16 bits), 0x10 pull-up disable, 0x14 event, 0x18 interrupt enable, 0x1C force, 0x20 edge polarity. Every register except the drive mode register is 8 bits wide, and unused upper bits read 0. Control bit 0 is clock request and bit 1 is sync-select, stored and read back.
- R3: The input register shows a pad level only after it has passed two flip-flops: the value is still old after one rising edge and new after the second.
- R4: Pin n's mode sits in drive register bits 2n+1:2n. Code 00 is input (no drive). Code 01 is push-pull (drive the data bit). Code 10 is open-drain (drive 0 only while the data bit is 0). Code 11 is open-source (drive 1 only while the data bit is 1).
- R5: A pin's pull-up enable output is the inverse of its pull-up disable bit.
- R6: A polarity bit of 1 selects the rising edge and 0 selects the falling edge. The selected edge of the synchronized level sets the pin's event bit one clock later. The opposite edge sets nothing.
- R7: Event bits stay set until software writes 1 to them. Writing 0 has no effect.
- R8: Event bits latch whether or not they are enabled. Port p's interrupt line is high exactly when some pin of port p has both its event bit and its enable bit set, and no other port's state affects it.
- R9: A force bit held at 1 sets its event bit on every cycle, so a clear write cannot clear it. Writing 0 to the force bit stops the forcing.
- R10: While clock request is 0, writes to port registers are ignored and no edge or force sets an event. The control register stays writable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational) |
| pad_in | input | NUM_PORTS*8 | Raw pad levels |
| pad_oe | output | NUM_PORTS*8 | Pad driver enable |
| pad_out | output | NUM_PORTS*8 | Pad driven value |
| pad_pu_en | output | NUM_PORTS*8 | Pull-up enable |
| irq | output | NUM_PORTS | One interrupt line per port |

## Verification
The hardest case to reach is an event bit that must stay set while a clear write targets it. Reaching it needs a force bit that is held high, and the result has to be told apart from an ordinary re-detected edge. The bench reaches it by writing the force register, confirming the event, and then issuing the clear with all pads quiet. It then releases the force and clears again. A second hard case is gating by the clock-request bit. There the bench toggles a pad through both edges while the bit is clear, then sets the bit again and confirms that no event appeared and that a port write made during the gated period was lost.

// File: rtl/pinbank_pkg.sv
package pinbank_pkg;
  typedef logic [5:0] reg_off_t;

  localparam reg_off_t OFF_DIN  = 6'h04;
  localparam reg_off_t OFF_DOUT = 6'h08;
  localparam reg_off_t OFF_MODE = 6'h0C;
  localparam reg_off_t OFF_PUD  = 6'h10;
  localparam reg_off_t OFF_EVT  = 6'h14;
  localparam reg_off_t OFF_IEN  = 6'h18;
  localparam reg_off_t OFF_FRC  = 6'h1C;
  localparam reg_off_t OFF_POL  = 6'h20;

  localparam logic [1:0] MODE_IN = 2'b00;
  localparam logic [1:0] MODE_PP = 2'b01;
  localparam logic [1:0] MODE_OD = 2'b10;
  localparam logic [1:0] MODE_OS = 2'b11;

  // returns {enable, value}
  function automatic logic [1:0] drive_of(input logic [1:0] mode, input logic d);
    case (mode)
      MODE_PP: drive_of = {1'b1, d};
      MODE_OD: drive_of = {~d, 1'b0};
      MODE_OS: drive_of = {d, 1'b1};
      default: drive_of = 2'b00;
    endcase
  endfunction

  function automatic logic edge_hit(input logic rise_sel, input logic prev, input logic cur);
    edge_hit = rise_sel ? (cur & ~prev) : (prev & ~cur);
  endfunction
endpackage

// File: rtl/pinbank_sync.sv
module pinbank_sync #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= '0;
      q      <= '0;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end
endmodule

// File: rtl/pinbank_port.sv
module pinbank_port
  import pinbank_pkg::*;
#(
  parameter int PW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          active,
  input  logic          wr_en,
  input  reg_off_t      off,
  input  logic [2*PW-1:0] wdata,
  output logic [31:0]   rdata,
  input  logic [PW-1:0] lvl,
  output logic [PW-1:0] oe,
  output logic [PW-1:0] dv,
  output logic [PW-1:0] pu,
  output logic [PW-1:0] det_o,
  output logic [PW-1:0] evt_o,
  output logic [PW-1:0] ien_o,
  output logic [2*PW-1:0] mode_o,
  output logic          irq
);
  logic [PW-1:0]   dout_q, pud_q, evt_q, ien_q, frc_q, pol_q, prev_q;
  logic [2*PW-1:0] mode_q;
  logic [PW-1:0]   det, clr, evt_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout_q <= '0; pud_q <= '0; ien_q <= '0; frc_q <= '0;
      pol_q  <= '0; mode_q <= '0; prev_q <= '0; evt_q <= '0;
    end else begin
      prev_q <= lvl;
      evt_q  <= evt_d;
      if (wr_en) begin
        case (off)
          OFF_DOUT: dout_q <= wdata[PW-1:0];
          OFF_MODE: mode_q <= wdata;
          OFF_PUD:  pud_q  <= wdata[PW-1:0];
          OFF_IEN:  ien_q  <= wdata[PW-1:0];
          OFF_FRC:  frc_q  <= wdata[PW-1:0];
          OFF_POL:  pol_q  <= wdata[PW-1:0];
          default: ;
        endcase
      end
    end
  end

  assign clr   = (wr_en && off == OFF_EVT) ? wdata[PW-1:0] : '0;
  assign evt_d = active ? ((evt_q & ~clr) | det | frc_q) : evt_q;

  for (genvar i = 0; i < PW; i++) begin : g_pin
    assign det[i] = edge_hit(pol_q[i], prev_q[i], lvl[i]);
    assign {oe[i], dv[i]} = drive_of(mode_q[2*i +: 2], dout_q[i]);
  end

  assign pu     = ~pud_q;
  assign irq    = |(evt_q & ien_q);
  assign det_o  = det;
  assign evt_o  = evt_q;
  assign ien_o  = ien_q;
  assign mode_o = mode_q;

  always_comb begin
    rdata = '0;
    case (off)
      OFF_DIN:  rdata[PW-1:0]   = lvl;
      OFF_DOUT: rdata[PW-1:0]   = dout_q;
      OFF_MODE: rdata[2*PW-1:0] = mode_q;
      OFF_PUD:  rdata[PW-1:0]   = pud_q;
      OFF_EVT:  rdata[PW-1:0]   = evt_q;
      OFF_IEN:  rdata[PW-1:0]   = ien_q;
      OFF_FRC:  rdata[PW-1:0]   = frc_q;
      OFF_POL:  rdata[PW-1:0]   = pol_q;
      default:  rdata = '0;
    endcase
  end
endmodule

// File: rtl/pinbank_ctrl.sv
module pinbank_ctrl
  import pinbank_pkg::*;
#(
  parameter int         NUM_PORTS     = 3,
  parameter int         PINS_PER_PORT = 8,
  parameter int         STRIDE        = 48,
  parameter int         ADDR_W        = 8,
  parameter logic [6:0] VERSION_ID    = 7'h15
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               bus_wr,
  input  logic [ADDR_W-1:0]                  bus_addr,
  input  logic [31:0]                        bus_wdata,
  output logic [31:0]                        bus_rdata,
  input  logic [NUM_PORTS*PINS_PER_PORT-1:0] pad_in,
  output logic [NUM_PORTS*PINS_PER_PORT-1:0] pad_oe,
  output logic [NUM_PORTS*PINS_PER_PORT-1:0] pad_out,
  output logic [NUM_PORTS*PINS_PER_PORT-1:0] pad_pu_en,
  output logic [NUM_PORTS-1:0]               irq
);
  localparam int NPIN = NUM_PORTS * PINS_PER_PORT;
  localparam int MW   = 2 * PINS_PER_PORT;

  logic              clk_req, sync_sel;
  logic [NPIN-1:0]   pad_lvl, det_all, evt_all, ien_all;
  logic [NUM_PORTS*MW-1:0] cfg_all;
  logic [ADDR_W-1:0] q_idx, q_off;
  logic              is_ctrl;
  logic [31:0]       ctrl_rd;
  logic [31:0]       prd [NUM_PORTS];
  logic [NUM_PORTS-1:0] port_wr;
  logic              unused_bits;

  assign unused_bits = ^{bus_wdata[31:MW], q_off[ADDR_W-1:6]};

  assign q_idx   = bus_addr / ADDR_W'(STRIDE);
  assign q_off   = bus_addr % ADDR_W'(STRIDE);
  assign is_ctrl = (bus_addr == '0);
  assign ctrl_rd = {16'h0, 7'(NUM_PORTS), VERSION_ID, sync_sel, clk_req};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clk_req  <= 1'b0;
      sync_sel <= 1'b0;
    end else if (bus_wr && is_ctrl) begin
      clk_req  <= bus_wdata[0];
      sync_sel <= bus_wdata[1];
    end
  end

  pinbank_sync #(.W(NPIN)) sync_i (
    .clk(clk), .rst_n(rst_n), .d(pad_in), .q(pad_lvl)
  );

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    localparam int LO = p * PINS_PER_PORT;
    assign port_wr[p] = bus_wr && clk_req && !is_ctrl && (q_idx == ADDR_W'(p));

    pinbank_port #(.PW(PINS_PER_PORT)) port_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .active (clk_req),
      .wr_en  (port_wr[p]),
      .off    (q_off[5:0]),
      .wdata  (bus_wdata[MW-1:0]),
      .rdata  (prd[p]),
      .lvl    (pad_lvl[LO +: PINS_PER_PORT]),
      .oe     (pad_oe[LO +: PINS_PER_PORT]),
      .dv     (pad_out[LO +: PINS_PER_PORT]),
      .pu     (pad_pu_en[LO +: PINS_PER_PORT]),
      .det_o  (det_all[LO +: PINS_PER_PORT]),
      .evt_o  (evt_all[LO +: PINS_PER_PORT]),
      .ien_o  (ien_all[LO +: PINS_PER_PORT]),
      .mode_o (cfg_all[p*MW +: MW]),
      .irq    (irq[p])
    );
  end

  always_comb begin
    bus_rdata = '0;
    if (is_ctrl) begin
      bus_rdata = ctrl_rd;
    end else begin
      for (int p = 0; p < NUM_PORTS; p++)
        if (q_idx == ADDR_W'(p)) bus_rdata = prd[p];
    end
  end
endmodule

// File: rtl/pinbank_ctrl_chk.sv
module pinbank_ctrl_chk #(
  parameter int NP = 3,
  parameter int PW = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bus_wr,
  input logic             clk_req,
  input logic [NP*PW-1:0] pad_oe,
  input logic [NP*PW-1:0] pad_out,
  input logic [NP-1:0]    irq,
  input logic [NP*PW-1:0] det_all,
  input logic [NP*PW-1:0] evt_all,
  input logic [NP*PW-1:0] ien_all,
  input logic [NP*2*PW-1:0] cfg_all
);
  localparam int N = NP * PW;
  logic [N-1:0] in_m, od_m, os_m;

  always_comb begin
    for (int i = 0; i < N; i++) begin
      in_m[i] = (cfg_all[2*i +: 2] == 2'b00);
      od_m[i] = (cfg_all[2*i +: 2] == 2'b10);
      os_m[i] = (cfg_all[2*i +: 2] == 2'b11);
    end
  end

  a_r4_input_no_drive: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_oe & in_m) == '0);
  a_r4_open_drain_low: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_oe & pad_out & od_m) == '0);
  a_r4_open_source_high: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_oe & ~pad_out & os_m) == '0);
  a_r6_edge_latches: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_req && det_all != '0) |=> ((evt_all & $past(det_all)) == $past(det_all)));
  a_r7_events_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_wr |=> (($past(evt_all) & ~evt_all) == '0));
  a_r10_gated_no_new_events: assert property (@(posedge clk) disable iff (!rst_n)
    !clk_req |=> ((evt_all & ~$past(evt_all)) == '0));

  for (genvar p = 0; p < NP; p++) begin : g_irq
    a_r8_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
      irq[p] |-> ((ien_all[p*PW +: PW] & evt_all[p*PW +: PW]) != '0));
  end
endmodule

bind pinbank_ctrl pinbank_ctrl_chk #(.NP(NUM_PORTS), .PW(PINS_PER_PORT)) chk_i (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .clk_req(clk_req),
  .pad_oe(pad_oe), .pad_out(pad_out), .irq(irq), .det_all(det_all),
  .evt_all(evt_all), .ien_all(ien_all), .cfg_all(cfg_all)
);

// File: tb/pinbank_ctrl_tb.sv
module pinbank_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 3;

  logic        clk = 0, rst_n = 0, bus_wr = 0;
  logic [7:0]  bus_addr = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic [23:0] pad_in = 0, pad_oe, pad_out, pad_pu_en;
  logic [2:0]  irq;
  int checks = 0, errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pinbank_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
    .pad_oe(pad_oe), .pad_out(pad_out), .pad_pu_en(pad_pu_en), .irq(irq)
  );

  function automatic logic [7:0] ra(int p, int off);
    return 8'(p * 48 + off);
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rd_chk(string tag, logic [7:0] a, logic [31:0] exp);
    bus_addr = a; #1;
    check(tag, bus_rdata, exp);
  endtask

  task automatic wait_n(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    rd_chk("R1 ctrl id", 8'h00, 32'h0000_0654);
    rd_chk("R1 mode reg", ra(1, 'h0C), 0);
    rd_chk("R1 event reg", ra(2, 'h14), 0);
    check("R1 oe", pad_oe, 0);
    check("R1 pullup", pad_pu_en, 24'hFF_FFFF);
    check("R1 irq", irq, 0);
    wr(8'h00, 1);
    rd_chk("R2 ctrl enable", 8'h00, 32'h0000_0655);
  endtask

  task automatic t_map;
    wr(ra(2, 'h08), 32'hFFFF_FFA5);
    rd_chk("R2 dout p2", ra(2, 'h08), 32'hA5);
    wr(ra(1, 'h0C), 32'h1234_ABCD);
    rd_chk("R2 mode 16b", ra(1, 'h0C), 32'hABCD);
    rd_chk("R2 dout p1 untouched", ra(1, 'h08), 0);
    wr(ra(1, 'h0C), 0);
    wr(ra(0, 'h04), 32'hFF);
    rd_chk("R2 din read-only", ra(0, 'h04), 0);
  endtask

  task automatic t_sync;
    @(negedge clk); pad_in[9] = 1;
    wait_n(1);
    rd_chk("R3 one edge old", ra(1, 'h04), 0);
    wait_n(1);
    rd_chk("R3 two edges new", ra(1, 'h04), 32'h02);
  endtask

  task automatic t_drive;
    wr(ra(0, 'h0C), 32'h00E4);
    wr(ra(0, 'h08), 32'h00);
    check("R4 oe dout0", pad_oe[3:0], 4'b0110);
    check("R4 out dout0", pad_out[3:0] & pad_oe[3:0], 4'b0000);
    wr(ra(0, 'h08), 32'h0F);
    check("R4 oe dout1", pad_oe[3:0], 4'b1010);
    check("R4 out dout1", pad_out[3:0] & pad_oe[3:0], 4'b1010);
  endtask

  task automatic t_pull;
    wr(ra(2, 'h10), 32'h0F);
    check("R5 pullup p2", pad_pu_en[23:16], 8'hF0);
    check("R5 pullup p0", pad_pu_en[7:0], 8'hFF);
  endtask

  task automatic t_edge;
    rd_chk("R6 rise ignored on falling pin", ra(1, 'h14), 0);
    wr(ra(1, 'h20), 32'h01);
    @(negedge clk); pad_in[8] = 1;
    wait_n(3);
    rd_chk("R6 rising pin0", ra(1, 'h14), 32'h01);
    @(negedge clk); pad_in[9] = 0;
    wait_n(3);
    rd_chk("R6 falling pin1", ra(1, 'h14), 32'h03);
    @(negedge clk); pad_in[9] = 1; pad_in[8] = 0;
    wait_n(3);
    rd_chk("R6 opposite edges ignored", ra(1, 'h14), 32'h03);
    check("R8 irq off while disabled", irq, 0);
  endtask

  task automatic t_w1c_irq;
    wr(ra(1, 'h18), 32'h02);
    check("R8 irq port1", irq, 3'b010);
    wr(ra(1, 'h14), 32'h00);
    rd_chk("R7 write zero no effect", ra(1, 'h14), 32'h03);
    wr(ra(1, 'h14), 32'h02);
    rd_chk("R7 clear pin1", ra(1, 'h14), 32'h01);
    check("R8 irq drops", irq, 0);
    wr(ra(1, 'h14), 32'h01);
    rd_chk("R7 clear pin0", ra(1, 'h14), 0);
  endtask

  task automatic t_force;
    wr(ra(2, 'h1C), 32'h80);
    wait_n(1);
    rd_chk("R9 force sets", ra(2, 'h14), 32'h80);
    wr(ra(2, 'h14), 32'h80);
    rd_chk("R9 force beats clear", ra(2, 'h14), 32'h80);
    wr(ra(2, 'h1C), 32'h00);
    wr(ra(2, 'h14), 32'h80);
    wait_n(1);
    rd_chk("R9 clear after release", ra(2, 'h14), 0);
  endtask

  task automatic t_gate;
    wr(8'h00, 32'h2);
    rd_chk("R10 ctrl write while off", 8'h00, 32'h0000_0656);
    wr(ra(2, 'h08), 32'h3C);
    rd_chk("R10 port write ignored", ra(2, 'h08), 32'hA5);
    @(negedge clk); pad_in[16] = 1;
    wait_n(3);
    @(negedge clk); pad_in[16] = 0;
    wait_n(3);
    rd_chk("R10 no event when gated", ra(2, 'h14), 0);
    wr(8'h00, 32'h1);
    wait_n(2);
    rd_chk("R10 re-enabled ctrl", 8'h00, 32'h0000_0655);
    rd_chk("R10 no late event", ra(2, 'h14), 0);
  endtask

  initial begin
    wait_n(3);
    rst_n = 1;
    wait_n(1);
    t_reset();
    t_map();
    t_sync();
    t_drive();
    t_pull();
    t_edge();
    t_w1c_irq();
    t_force();
    t_gate();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule